// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter

This block is a seven-tap halfband FIR filter that decimates by two. Only the outputs kept by the decimation are computed. The sample stream is split into even-indexed and odd-indexed halves. The even half feeds a four-tap branch that holds coefficients C0, C2, C4 and C6. The odd half feeds a short delay and a single multiplier by the centre coefficient C3. C1 and C5 are zero for a halfband response, so they have no hardware. The two branch results are added into a full-precision accumulator. The sum then goes through a rounding stage that selects the output precision, saturates, and gives a signed 16-bit result with a one-cycle valid pulse.

Samples can arrive in two ways. In the first, one interleaved stream arrives on one lane and the block works out the even/odd phase itself. In the second, every strobe carries an even sample and the odd sample that follows it, on two lanes. The five stored coefficients are written through a small write port while the filter is idle.

Top module: `hb_decim2`

## Requirements
- R1: While reset is low and after it is released, y_vld is 0 and y_dat is 0. All stored coefficients and delay taps are zero. The next accepted sample is index 0.
- R2: Each result is Y(k) = X(2k)·C0 + X(2k+2)·C2 + X(2k+4)·C4 + X(2k+6)·C6 + X(2k+3)·C3, with 16-bit two's-complement samples and coefficients. C1 and C5 are taken as zero.
- R3: With lane_mode = 0, each strobe carries one sample on smp_a. Samples alternate even and odd, starting at even. Each even sample from index 6 onward completes one result, so there is one result per two samples.
- R4: With lane_mode = 1, each strobe carries X(2m) on smp_a and X(2m+1) on smp_b. Every strobe from the fourth onward (m ≥ 3) completes one result.
- R5: y_vld is high for one cycle per result. It is seen after the second rising edge that follows the edge accepting the even sample that completes the result. No other pulses occur.
- R6: Idle cycles between strobes have no effect on the results or on the phase.
- R7: A write with cw_en = 1 stores cw_val into C0, C2, C4 or C6 for cw_idx 0, 1, 2 or 3, and into C3 for cw_idx 4. Indexes 5, 6 and 7 change nothing.
- R8: The products are in Q15. For prec_sel codes 0..6, D is 8, 7, 6, 5, 4, 2 and 0, so 8, 9, 10, 11, 12, 14 or 16 bits are kept. The result is floor((acc + 2^(14+D)) / 2^(15+D)) · 2^D, where acc is the exact sum from R2. The low D bits are zero.
- R9: A rounded value above 32767 becomes 0x7FFF with the low D bits cleared. A value below −32768 becomes 0x8000. The value never wraps.
- R10: prec_sel = 7 gives y_dat = 0 for every result.
- R11: y_dat holds its value in every cycle in which y_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_a | input | 16 | Interleaved sample (lane_mode 0) or even sample (lane_mode 1) |
| smp_b | input | 16 | Odd sample in lane_mode 1, unused otherwise |
| lane_mode | input | 1 | 0: split internally, 1: split on arrival |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | 3 | Coefficient select |
| cw_val | input | 16 | Coefficient value |
| prec_sel | input | 3 | Output precision code |
| y_vld | output | 1 | Result strobe |
| y_dat | output | 16 | Decimated result |

## Verification
The in-line assertions check on every cycle several properties:
- a result strobe always follows its accumulator strobe;
- the output holds while no result is due;
- the zero code forces zeros;
- the 8-bit code clears the low bits;
- a positive sum never comes out negative;
- an accepted result always comes from an even sample;
- dual-lane strobes always carry both halves.

Only the bench scenarios can show that the arithmetic is right:
- each retained output pairs the right samples with the right coefficients;
- the phase restarts after reset;
- ignored write indexes leave the coefficients unchanged;
- the saturated values are exact.

// File: rtl/hb_dec_pkg.sv
package hb_dec_pkg;

  typedef enum logic [2:0] {
    PREC_8    = 3'd0,
    PREC_9    = 3'd1,
    PREC_10   = 3'd2,
    PREC_11   = 3'd3,
    PREC_12   = 3'd4,
    PREC_14   = 3'd5,
    PREC_16   = 3'd6,
    PREC_ZERO = 3'd7
  } prec_e;

  // number of output bits kept for a precision code
  function automatic int keep_bits(input logic [2:0] code);
    case (code)
      3'd0:    keep_bits = 8;
      3'd1:    keep_bits = 9;
      3'd2:    keep_bits = 10;
      3'd3:    keep_bits = 11;
      3'd4:    keep_bits = 12;
      3'd5:    keep_bits = 14;
      default: keep_bits = 16;
    endcase
  endfunction

endpackage

// File: rtl/hb_coef_bank.sv
module hb_coef_bank #(
  parameter int W  = 16,
  parameter int NE = 4,
  parameter int SW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cw_en,
  input  logic [SW-1:0]         cw_idx,
  input  logic [W-1:0]          cw_val,
  output logic [NE-1:0][W-1:0]  c_even,
  output logic [W-1:0]          c_ctr
);

  logic [NE-1:0][W-1:0] ce_q, ce_n;
  logic [W-1:0]         cc_q, cc_n;

  for (genvar j = 0; j < NE; j++) begin : g_even
    always_comb begin
      ce_n[j] = ce_q[j];
      if (cw_en && (cw_idx == SW'(j))) ce_n[j] = cw_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_q[j] <= '0;
      else        ce_q[j] <= ce_n[j];
    end
  end

  always_comb begin
    cc_n = cc_q;
    if (cw_en && (cw_idx == SW'(NE))) cc_n = cw_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= '0;
    else        cc_q <= cc_n;
  end

  assign c_even = ce_q;
  assign c_ctr  = cc_q;

endmodule

// File: rtl/hb_splitter.sv
module hb_splitter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_a,
  input  logic [W-1:0] smp_b,
  input  logic         lane_ext,
  output logic         ev_stb,
  output logic [W-1:0] ev_dat,
  output logic         od_stb,
  output logic [W-1:0] od_dat
);

  // phase_q = 1 means the next single-lane sample has an odd index
  logic phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    if (lane_ext)     phase_n = 1'b0;
    else if (smp_vld) phase_n = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_n;
  end

  always_comb begin
    if (lane_ext) begin
      ev_stb = smp_vld;
      od_stb = smp_vld;
      od_dat = smp_b;
    end else begin
      ev_stb = smp_vld && !phase_q;
      od_stb = smp_vld && phase_q;
      od_dat = smp_a;
    end
    ev_dat = smp_a;
  end

endmodule

// File: rtl/hb_branches.sv
module hb_branches #(
  parameter int W     = 16,
  parameter int NE    = 4,
  parameter int ND    = 2,
  parameter int ACC_W = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lane_ext,
  input  logic                    ev_stb,
  input  logic [W-1:0]            ev_dat,
  input  logic                    od_stb,
  input  logic [W-1:0]            od_dat,
  input  logic [NE-1:0][W-1:0]    c_even,
  input  logic [W-1:0]            c_ctr,
  output logic                    acc_vld,
  output logic signed [ACC_W-1:0] acc
);

  localparam int PCW = (NE > 1) ? $clog2(NE) : 1;
  localparam int PW  = 2 * W;

  // stage 1: delay lines, centre operand capture, priming
  logic [NE-1:0][W-1:0] ev_q, ev_n;
  logic [ND-1:0][W-1:0] od_q, od_n;
  logic [W-1:0]         ctr_q, ctr_n;
  logic [PCW-1:0]       cnt_q, cnt_n;
  logic                 fire_q, fire_n;
  logic                 primed;

  assign ev_n[0] = ev_stb ? ev_dat : ev_q[0];
  for (genvar j = 1; j < NE; j++) begin : g_ev_shift
    assign ev_n[j] = ev_stb ? ev_q[j-1] : ev_q[j];
  end

  assign od_n[0] = od_stb ? od_dat : od_q[0];
  for (genvar j = 1; j < ND; j++) begin : g_od_shift
    assign od_n[j] = od_stb ? od_q[j-1] : od_q[j];
  end

  assign primed = (cnt_q == PCW'(NE - 1));

  always_comb begin
    ctr_n  = ev_stb ? od_q[ND-1] : ctr_q;
    cnt_n  = (ev_stb && !primed) ? cnt_q + 1'b1 : cnt_q;
    fire_n = ev_stb && primed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      od_q   <= '0;
      ctr_q  <= '0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      ev_q   <= ev_n;
      od_q   <= od_n;
      ctr_q  <= ctr_n;
      cnt_q  <= cnt_n;
      fire_q <= fire_n;
    end
  end

  // stage 2: multiply both branches and sum
  logic signed [PW-1:0]    prod [NE];
  logic signed [PW-1:0]    prod_ctr;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_q, acc_n;
  logic                    av_q, av_n;

  for (genvar j = 0; j < NE; j++) begin : g_mul
    // newest even sample meets the highest even coefficient
    assign prod[j] = $signed(ev_q[j]) * $signed(c_even[NE-1-j]);
  end
  assign prod_ctr = $signed(ctr_q) * $signed(c_ctr);

  always_comb begin
    sum = ACC_W'(prod_ctr);
    for (int j = 0; j < NE; j++) sum = sum + ACC_W'(prod[j]);
    acc_n = fire_q ? sum : acc_q;
    av_n  = fire_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      av_q  <= 1'b0;
    end else begin
      acc_q <= acc_n;
      av_q  <= av_n;
    end
  end

  assign acc     = acc_q;
  assign acc_vld = av_q;

  // R3: a result is launched only by an accepted even sample
  a_r3_fire_from_even: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(ev_stb));

  // R4: a dual-lane strobe delivers both halves together
  a_r4_pair_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_ext && ev_stb) |-> od_stb);

endmodule

// File: rtl/hb_rounder.sv
module hb_rounder
  import hb_dec_pkg::*;
#(
  parameter int W     = 16,
  parameter int ACC_W = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_vld,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [2:0]              prec_sel,
  output logic                    y_vld,
  output logic [W-1:0]            y_dat
);

  localparam int FRAC = W - 1;
  localparam int RW   = ACC_W + 1;
  localparam logic signed [RW-1:0] POS_LIM = RW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [RW-1:0] NEG_LIM = RW'(-(64'sd1 <<< (W - 1)));

  int                    drop;
  logic signed [RW-1:0]  half, rsum, shifted;
  logic [W-1:0]          clipped, keep_mask, rounded;
  logic [W-1:0]          y_dat_q, y_dat_n;
  logic                  y_vld_q, y_vld_n;

  always_comb begin
    drop = W - keep_bits(prec_sel);
    if (drop < 0) drop = 0;
    half    = RW'(1) <<< (FRAC + drop - 1);
    rsum    = RW'(acc) + half;
    shifted = rsum >>> FRAC;
    if (shifted > POS_LIM)      clipped = POS_LIM[W-1:0];
    else if (shifted < NEG_LIM) clipped = NEG_LIM[W-1:0];
    else                        clipped = shifted[W-1:0];
    keep_mask = {W{1'b1}} << drop;
    rounded   = (prec_sel == PREC_ZERO) ? '0 : (clipped & keep_mask);
    y_vld_n   = acc_vld;
    y_dat_n   = acc_vld ? rounded : y_dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_vld_q <= 1'b0;
      y_dat_q <= '0;
    end else begin
      y_vld_q <= y_vld_n;
      y_dat_q <= y_dat_n;
    end
  end

  assign y_vld = y_vld_q;
  assign y_dat = y_dat_q;

  // R5: every finished sum gives exactly one strobe, one cycle later
  a_r5_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> y_vld);

  a_r5_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !y_vld);

  // R11: output is held between results
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(y_dat));

  // R10: the zero code blanks the result
  a_r10_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && prec_sel == 3'd7) |=> (y_dat == '0));

  // R8: 8-bit precision leaves the low bits cleared
  a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && prec_sel == 3'd0) |=> (y_dat[W-9:0] == '0));

  // R9: a non-negative sum never comes out negative
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc[ACC_W-1] && prec_sel != 3'd7) |=> !y_dat[W-1]);

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int W     = 16,
  parameter int NTAPS = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [15:0]  smp_a,
  input  logic [15:0]  smp_b,
  input  logic         lane_mode,
  input  logic         cw_en,
  input  logic [2:0]   cw_idx,
  input  logic [15:0]  cw_val,
  input  logic [2:0]   prec_sel,
  output logic         y_vld,
  output logic [15:0]  y_dat
);

  localparam int NE    = (NTAPS + 1) / 2;
  localparam int CTR   = (NTAPS - 1) / 2;
  localparam int ND    = (CTR + 1) / 2;
  localparam int SW    = $clog2(NE + 1);
  localparam int ACC_W = 2 * W + $clog2(NE + 1);

  logic                    ev_stb, od_stb;
  logic [W-1:0]            ev_dat, od_dat;
  logic [NE-1:0][W-1:0]    c_even;
  logic [W-1:0]            c_ctr;
  logic                    acc_vld;
  logic signed [ACC_W-1:0] acc;

  hb_coef_bank #(.W(W), .NE(NE), .SW(SW)) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .cw_en  (cw_en),
    .cw_idx (SW'(cw_idx)),
    .cw_val (W'(cw_val)),
    .c_even (c_even),
    .c_ctr  (c_ctr)
  );

  hb_splitter #(.W(W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_a    (W'(smp_a)),
    .smp_b    (W'(smp_b)),
    .lane_ext (lane_mode),
    .ev_stb   (ev_stb),
    .ev_dat   (ev_dat),
    .od_stb   (od_stb),
    .od_dat   (od_dat)
  );

  hb_branches #(.W(W), .NE(NE), .ND(ND), .ACC_W(ACC_W)) u_branch (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_ext (lane_mode),
    .ev_stb   (ev_stb),
    .ev_dat   (ev_dat),
    .od_stb   (od_stb),
    .od_dat   (od_dat),
    .c_even   (c_even),
    .c_ctr    (c_ctr),
    .acc_vld  (acc_vld),
    .acc      (acc)
  );

  logic [W-1:0] y_int;

  hb_rounder #(.W(W), .ACC_W(ACC_W)) u_round (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_vld  (acc_vld),
    .acc      (acc),
    .prec_sel (prec_sel),
    .y_vld    (y_vld),
    .y_dat    (y_int)
  );

  assign y_dat = 16'(y_int);

endmodule

// File: tb/test_hb_decim2.sv
module test_hb_decim2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [15:0] smp_a, smp_b;
  logic        lane_mode;
  logic        cw_en;
  logic [2:0]  cw_idx;
  logic [15:0] cw_val;
  logic [2:0]  prec_sel;
  logic        y_vld;
  logic [15:0] y_dat;

  always #2.5 clk = ~clk;

  hb_decim2 i_hb_decim2 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_a(smp_a), .smp_b(smp_b),
    .lane_mode(lane_mode), .cw_en(cw_en), .cw_idx(cw_idx), .cw_val(cw_val),
    .prec_sel(prec_sel), .y_vld(y_vld), .y_dat(y_dat)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";
  int    xs[$];
  int    cm[5];
  int    exp_v[$];
  int    exp_c[$];
  logic [15:0] last_y = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int ref_round(input longint a, input int code);
    int     keep, d;
    longint s;
    if (code == 7) return 0;
    case (code)
      0: keep = 8;  1: keep = 9;  2: keep = 10; 3: keep = 11;
      4: keep = 12; 5: keep = 14; default: keep = 16;
    endcase
    d = 16 - keep;
    s = (a + (64'sd1 <<< (14 + d))) >>> (15 + d);
    s = s <<< d;
    if (s > 32767)  s = (32767 >>> d) <<< d;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  // result completed by the even sample at index n
  function automatic longint ref_acc(input int n);
    longint a;
    a = longint'(xs[n-6]) * cm[0] + longint'(xs[n-4]) * cm[1]
      + longint'(xs[n-2]) * cm[2] + longint'(xs[n])   * cm[3]
      + longint'(xs[n-3]) * cm[4];
    return a;
  endfunction

  task automatic put_sample(input int a, input int b);
    int n;
    @(negedge clk);
    smp_vld = 1'b1;
    smp_a   = a[15:0];
    smp_b   = b[15:0];
    xs.push_back(a);
    n = xs.size() - 1;
    if ((n % 2 == 0) && n >= 6) begin
      exp_v.push_back(ref_round(ref_acc(n), int'(prec_sel)));
      exp_c.push_back(cyc + 3);
    end
    if (lane_mode) xs.push_back(b);
  endtask

  task automatic gap(input int k);
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  task automatic drain();
    gap(7);
    chk(exp_v.size() == 0, "R5 missing result", exp_v.size(), 0);
  endtask

  task automatic wr_coef(input int idx, input int val);
    @(negedge clk);
    cw_en  = 1'b1;
    cw_idx = idx[2:0];
    cw_val = val[15:0];
    if (idx < 5) cm[idx] = val;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    lane_mode = mode;
    xs.delete();
    foreach (cm[i]) cm[i] = 0;
    repeat (2) @(negedge clk);
    chk(y_vld == 1'b0, "R1 y_vld in reset", int'(y_vld), 0);
    chk(y_dat == 16'h0, "R1 y_dat in reset", int'(y_dat), 0);
    rst_n = 1'b1;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      last_y = '0;
    end else if (y_vld) begin
      if (exp_v.size() == 0) begin
        chk(1'b0, "R5 unexpected strobe", int'($signed(y_dat)), 0);
      end else begin
        int ev, ec;
        ev = exp_v.pop_front();
        ec = exp_c.pop_front();
        chk(int'($signed(y_dat)) == ev, tag, int'($signed(y_dat)), ev);
        chk(cyc == ec, "R5 latency", cyc, ec);
      end
      last_y = y_dat;
    end else begin
      chk(y_dat == last_y, "R11 hold", int'(y_dat), int'(last_y));
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; smp_vld = 1'b0; smp_a = '0; smp_b = '0; lane_mode = 1'b0;
    cw_en = 1'b0; cw_idx = '0; cw_val = '0; prec_sel = 3'd6;
    foreach (cm[i]) cm[i] = 0;
    repeat (3) @(negedge clk);
    chk(y_vld == 1'b0, "R1 y_vld in reset", int'(y_vld), 0);
    chk(y_dat == 16'h0, "R1 y_dat in reset", int'(y_dat), 0);
    rst_n = 1'b1;

    // R1: zero coefficients after reset give zero results
    tag = "R1 zero coefficients";
    for (int i = 0; i < 10; i++) put_sample(rnd16(), 0);
    drain();

    // R2: directed ramp, C = 0.25 on every stored tap
    tag = "R2 formula";
    for (int i = 0; i < 5; i++) wr_coef(i, 8192);
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) wr_coef(i, 8192);
    for (int i = 0; i < 9; i++) put_sample(i * 64, 0);
    drain();
    chk($signed(last_y) == 400, "R2 ramp Y(1)", int'($signed(last_y)), 400);

    // R3: single-lane random stream, back to back
    tag = "R3 single lane";
    for (int i = 0; i < 5; i++) wr_coef(i, int'($urandom_range(0, 32767)) - 16384);
    for (int i = 0; i < 60; i++) put_sample(rnd16(), 0);
    drain();

    // R7: writes to unused indexes leave the taps alone
    wr_coef(5, 32767);
    wr_coef(6, -32768);
    wr_coef(7, 12345);
    tag = "R7 ignored index";
    for (int i = 0; i < 20; i++) put_sample(rnd16(), 0);
    drain();

    // R6: idle cycles between samples
    tag = "R6 idle gaps";
    for (int i = 0; i < 40; i++) begin
      put_sample(rnd16(), 0);
      if ($urandom_range(0, 1) == 1) gap(int'($urandom_range(1, 4)));
    end
    drain();

    // R8: every precision code
    for (int c = 0; c < 7; c++) begin
      prec_sel = c[2:0];
      tag = "R8 precision";
      for (int i = 0; i < 16; i++) put_sample(rnd16(), 0);
      drain();
    end

    // R10: zero code
    prec_sel = 3'd7;
    tag = "R10 zero code";
    for (int i = 0; i < 16; i++) put_sample(rnd16(), 0);
    drain();

    // R9: saturation at both ends
    prec_sel = 3'd0;
    tag = "R9 saturation";
    for (int i = 0; i < 5; i++) wr_coef(i, 32767);
    for (int i = 0; i < 10; i++) put_sample(32767, 0);
    drain();
    chk(last_y == 16'h7F00, "R9 positive clip 8 bit", int'(last_y), 32512);
    prec_sel = 3'd6;
    for (int i = 0; i < 10; i++) put_sample(-32768, 0);
    drain();
    chk(last_y == 16'h8000, "R9 negative clip", int'(last_y), 32768);
    for (int i = 0; i < 10; i++) put_sample(32767, 0);
    drain();
    chk(last_y == 16'h7FFF, "R9 positive clip 16 bit", int'(last_y), 32767);

    // R4: dual-lane stream after reset, phase restarts at index 0
    do_reset(1'b1);
    tag = "R1 cleared taps";
    for (int i = 0; i < 6; i++) put_sample(rnd16(), rnd16());
    drain();
    for (int i = 0; i < 5; i++) wr_coef(i, int'($urandom_range(0, 32767)) - 16384);
    tag = "R4 dual lane";
    for (int i = 0; i < 40; i++) begin
      put_sample(rnd16(), rnd16());
      if ($urandom_range(0, 3) == 0) gap(int'($urandom_range(1, 3)));
    end
    drain();
    wr_coef(5, -1);
    tag = "R7 ignored index dual lane";
    for (int i = 0; i < 12; i++) put_sample(rnd16(), rnd16());
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule